// File: doc/BRIEF.md
# Frame Alignment Offset Meter

The block measures how late a chosen frame evaluation input falls after the local frame start. Software first writes a five-bit select value that picks one of 24 evaluation inputs. It then raises the arm control. The meter waits for the next frame start pulse and counts clock cycles from that pulse. It stops at the first falling edge of the selected input. The input is sampled on both clock edges, so the result also reports which half of the clock period held the edge.

The result is a 16-bit status word, read-only apart from the select field. Bits 15:11 hold the select value. Bit 10 is the done flag. Bit 9 is the phase bit. Bits 8:0 hold the delay count. The selected input passes through a two-stage synchroniser before edge detection, so every delay carries a fixed latency of two cycles. A result stays frozen until the arm control is dropped. Dropping it clears bits 10:0.

The controller is a four-state machine. IDLE is the disarmed state. IDLE goes to WAIT_FRAME when arm is seen high. WAIT_FRAME goes to COUNT on a frame start pulse. COUNT goes to DONE when the falling edge is detected or the counter reaches 511. DONE holds. Every state returns to IDLE as soon as arm is low.

Top module: `frame_offset_meter`

## Requirements
- R1: After reset the status word reads 0x0000.
- R2: A cycle with `sel_wr` high loads `sel_wdata` into status bits 15:11. Such a write leaves bits 10:0 unchanged.
- R3: Let the frame start pulse be sampled at rising edge F. Let the first rising edge that samples the selected input low be F+m. Then bits 8:0 read m+2, limited to 511.
- R4: Bit 9 reads 0 when the falling edge lies in the high half of the clock, so that the falling-edge sampler sees it first. It reads 1 when the edge lies in the low half, so that only the next rising edge sees it. Bit 9 is never 1 while bit 10 is 0.
- R5: Bit 10 becomes 1 once a result is stored. Counting starts only at the first frame start pulse after arming. A pulse that arrives while disarmed has no effect.
- R6: While bit 10 is 1 and arm stays high, bits 10:0 do not change, whatever frame pulses or input edges arrive.
- R7: One cycle after arm is sampled low, bits 10:0 read zero. Bits 15:11 keep the select value.
- R8: If no falling edge is detected before the count reaches 511, the status reads delay 511, phase 0 and done 1.
- R9: Select values 24 to 31 choose no input. A measurement with such a select always ends as in R8.
- R10: Edges on unselected inputs have no effect. The measurement saturates as in R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; both edges are used for sampling |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle local frame start pulse |
| eval_in | input | 24 | Frame evaluation inputs, idle high |
| sel_wr | input | 1 | Write strobe for the select field |
| sel_wdata | input | 5 | New select value |
| start_eval | input | 1 | Arm control; a falling level clears results |
| status | output | 16 | {select, done, phase, delay[8:0]} |

## Verification
The bench places edges in either half of the clock. A design that swapped the two samplers would report the opposite phase, and one that miscounted the pipeline would be off by one. Offsets of 509 and 510 check that a real edge found as the counter saturates keeps its phase. Offsets past 510 must read 511 with phase 0, so a counter that wraps would read a small delay. Other cases use a disarmed frame pulse, a select of 27 and a fall on an unselected input. A design that counted from a stale pulse or decoded a bad select would end early. After done, further pulses and edges must not disturb the result. Dropping arm must clear bits 10:0 and keep the select field.

// File: rtl/fom_pkg.sv
`timescale 1ns/1ps
package fom_pkg;
    localparam int unsigned N_INPUTS = 24;
    localparam int unsigned SEL_W    = 5;
    localparam int unsigned CNT_W    = 9;
    localparam int unsigned STAT_W   = SEL_W + 2 + CNT_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_FRAME,
        ST_COUNT,
        ST_DONE
    } fom_state_t;
endpackage

// File: rtl/fom_input_select.sv
`timescale 1ns/1ps
module fom_input_select #(
    parameter int unsigned N_IN = 24,
    parameter int unsigned SW   = 5
) (
    input  logic [N_IN-1:0] lines,
    input  logic [SW-1:0]   sel,
    output logic            picked
);
    logic [N_IN-1:0] low_hit;

    // An unmatched select sees no low line, so picked stays at idle high.
    for (genvar i = 0; i < N_IN; i++) begin : g_line
        assign low_hit[i] = (sel == SW'(i)) & ~lines[i];
    end

    assign picked = ~|low_hit;
endmodule

// File: rtl/fom_edge_sampler.sv
`timescale 1ns/1ps
module fom_edge_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic fall_det,
    output logic fall_phase
);
    // Rising-edge path: two synchroniser flops plus a history flop.
    logic rs1, rs2, rs_prev;
    // Falling-edge path: capture, retime, second stage.
    logic fs1, fs2, fs3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs1     <= 1'b1;
            rs2     <= 1'b1;
            rs_prev <= 1'b1;
            fs2     <= 1'b1;
            fs3     <= 1'b1;
        end else begin
            rs1     <= raw;
            rs2     <= rs1;
            rs_prev <= rs2;
            fs2     <= fs1;
            fs3     <= fs2;
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fs1 <= 1'b1;
        else        fs1 <= raw;
    end

    // fs3 holds the half-cycle sample taken between the rs_prev and rs2 samples.
    assign fall_det   = rs_prev & ~(fs3 & rs2);
    assign fall_phase = fs3;
endmodule

// File: rtl/fom_ctrl.sv
`timescale 1ns/1ps
module fom_ctrl
    import fom_pkg::*;
#(
    parameter int unsigned CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic          frame_start,
    input  logic          fall_det,
    input  logic          fall_phase,
    output logic          done,
    output logic          phase,
    output logic [CW-1:0] delay
);
    localparam logic [CW-1:0] CNT_MAX = '1;

    fom_state_t    state, state_nx;
    logic [CW-1:0] cnt;
    logic          at_max;

    assign at_max = (cnt == CNT_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (!arm) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:       state_nx = ST_WAIT_FRAME;
                ST_WAIT_FRAME: if (frame_start) state_nx = ST_COUNT;
                ST_COUNT:      if (fall_det || at_max) state_nx = ST_DONE;
                ST_DONE:       state_nx = ST_DONE;
                default:       state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            done  <= 1'b0;
            phase <= 1'b0;
            delay <= '0;
        end else if (!arm) begin
            cnt   <= '0;
            done  <= 1'b0;
            phase <= 1'b0;
            delay <= '0;
        end else begin
            unique case (state)
                ST_IDLE:       cnt <= '0;
                ST_WAIT_FRAME: if (frame_start) cnt <= '0;
                ST_COUNT: begin
                    if (fall_det) begin
                        delay <= at_max ? CNT_MAX : CW'(cnt + 1'b1);
                        phase <= fall_phase;
                        done  <= 1'b1;
                    end else if (at_max) begin
                        delay <= CNT_MAX;
                        phase <= 1'b0;
                        done  <= 1'b1;
                    end else begin
                        cnt <= CW'(cnt + 1'b1);
                    end
                end
                ST_DONE:       cnt <= cnt;
                default:       cnt <= '0;
            endcase
        end
    end

    p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && arm) |=> ($stable(delay) && $stable(phase) && done));

    p_phase_needs_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        phase |-> done);

    p_delay_needs_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (delay == '0));
endmodule

// File: rtl/frame_offset_meter.sv
`timescale 1ns/1ps
module frame_offset_meter
    import fom_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic [N_INPUTS-1:0] eval_in,
    input  logic                sel_wr,
    input  logic [SEL_W-1:0]    sel_wdata,
    input  logic                start_eval,
    output logic [STAT_W-1:0]   status
);
    logic [SEL_W-1:0] sel_q;
    logic             raw_line;
    logic             fall_det, fall_phase;
    logic             done, phase;
    logic [CNT_W-1:0] delay;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sel_q <= '0;
        else if (sel_wr) sel_q <= sel_wdata;
    end

    fom_input_select #(.N_IN(N_INPUTS), .SW(SEL_W)) u_sel (
        .lines  (eval_in),
        .sel    (sel_q),
        .picked (raw_line)
    );

    fom_edge_sampler u_samp (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw        (raw_line),
        .fall_det   (fall_det),
        .fall_phase (fall_phase)
    );

    fom_ctrl #(.CW(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm         (start_eval),
        .frame_start (frame_start),
        .fall_det    (fall_det),
        .fall_phase  (fall_phase),
        .done        (done),
        .phase       (phase),
        .delay       (delay)
    );

    assign status = {sel_q, done, phase, delay};

    p_sel_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr |=> (status[STAT_W-1 -: SEL_W] == $past(sel_wdata)));

    p_clear_on_disarm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(start_eval) |=> (status[CNT_W+1:0] == '0));
endmodule

// File: tb/tb_frame_offset_meter.sv
`timescale 1ns/1ps
module tb_frame_offset_meter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic [23:0] eval_in = '1;
    logic        sel_wr = 1'b0;
    logic [4:0]  sel_wdata = '0;
    logic        start_eval = 1'b0;
    logic [15:0] status;

    int checks = 0;
    int errors = 0;

    frame_offset_meter dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .eval_in(eval_in),
        .sel_wr(sel_wr), .sel_wdata(sel_wdata), .start_eval(start_eval), .status(status)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected status from R3/R4/R8: delay m+2 capped at 511, phase from half.
    function automatic logic [15:0] exp_status(input int sel, input int m, input bit late);
        logic [8:0] d;
        logic       p;
        if (m <= 510) begin
            d = (m + 2 > 511) ? 9'd511 : 9'(m + 2);
            p = late;
        end else begin
            d = 9'd511;
            p = 1'b0;
        end
        return {5'(sel), 1'b1, p, d};
    endfunction

    function automatic logic [15:0] exp_sat(input int sel);
        return {5'(sel), 1'b1, 1'b0, 9'd511};
    endfunction

    task automatic write_sel(input int sel);
        @(posedge clk); #2;
        sel_wr = 1'b1; sel_wdata = 5'(sel);
        @(posedge clk); #2;
        sel_wr = 1'b0;
    endtask

    // Disarm, select, arm, pulse frame start, drop eval_in[pin] m cycles later.
    task automatic measure(input int sel, input int pin, input int m, input bit late,
                           output logic [15:0] got);
        @(posedge clk); #2;
        start_eval = 1'b0; eval_in = '1; frame_start = 1'b0;
        write_sel(sel);
        repeat (4) @(posedge clk);
        #2 start_eval = 1'b1;
        repeat (3) @(posedge clk);
        for (int j = 0; j <= m + 1; j++) begin
            @(posedge clk); #2;
            frame_start = (j == 0);
            if (j == m) begin
                if (late) #5;
                eval_in[pin] = 1'b0;
            end
        end
        repeat (((m > 520) ? 0 : 520 - m) + 8) @(posedge clk);
        #3 got = status;
    endtask

    initial begin
        #1_000_000;
        checks++; errors++;
        $display("FAIL R3 watchdog actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] got;
        logic [15:0] held;
        int seed;
        seed = $urandom(32'd20240611);

        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        #1 check("R1 reset", status, 16'h0000);

        // R2 select write
        write_sel(13);
        #1 check("R2 select load", status, {5'd13, 11'd0});

        // R3/R4 directed offsets, both halves
        measure(0, 0, 0, 1'b0, got);  check("R3 m=0 early", got, exp_status(0, 0, 1'b0));
        measure(1, 1, 0, 1'b1, got);  check("R4 m=0 late", got, exp_status(1, 0, 1'b1));
        measure(23, 23, 1, 1'b0, got); check("R3 m=1 early", got, exp_status(23, 1, 1'b0));
        measure(5, 5, 6, 1'b1, got);  check("R4 m=6 late", got, exp_status(5, 6, 1'b1));
        measure(7, 7, 509, 1'b1, got); check("R3 m=509", got, exp_status(7, 509, 1'b1));
        measure(8, 8, 510, 1'b1, got); check("R4 m=510 edge at limit", got, exp_status(8, 510, 1'b1));

        // R8 saturation with a late edge
        measure(9, 9, 530, 1'b1, got); check("R8 saturate", got, exp_sat(9));

        // R9 invalid select
        measure(27, 3, 5, 1'b0, got);  check("R9 select 27", got, exp_sat(27));

        // R10 unselected input
        measure(4, 9, 5, 1'b0, got);   check("R10 other pin", got, exp_sat(4));

        // Random offsets
        for (int t = 0; t < 20; t++) begin
            int s, mm;
            bit lt;
            s  = int'($urandom_range(23, 0));
            mm = int'($urandom_range(60, 0));
            lt = 1'($urandom_range(1, 0));
            measure(s, s, mm, lt, got);
            check($sformatf("R3 R4 random sel=%0d m=%0d late=%0d", s, mm, lt),
                  got, exp_status(s, mm, lt));
        end

        // R6 frozen after done
        measure(11, 11, 7, 1'b0, got);
        held = got;
        check("R5 done set", got, exp_status(11, 7, 1'b0));
        @(posedge clk); #2 eval_in[11] = 1'b1; frame_start = 1'b1;
        @(posedge clk); #2 frame_start = 1'b0;
        repeat (6) @(posedge clk);
        #2 eval_in[11] = 1'b0;
        repeat (20) @(posedge clk);
        #3 check("R6 frozen", status, held);

        // R2 write while done leaves bits 10:0
        write_sel(17);
        #1 check("R2 write keeps result", status, {5'd17, held[10:0]});

        // R7 clear on disarm
        @(posedge clk); #2 start_eval = 1'b0;
        repeat (2) @(posedge clk);
        #3 check("R7 clear", status, {5'd17, 11'd0});

        // R5 pulse while disarmed is ignored; armed with no pulse never counts
        eval_in = '1;
        write_sel(2);
        @(posedge clk); #2 frame_start = 1'b1;
        @(posedge clk); #2 frame_start = 1'b0;
        repeat (3) @(posedge clk);
        #2 start_eval = 1'b1;
        repeat (530) @(posedge clk);
        #3 check("R5 no frame no count", status, {5'd2, 11'd0});
        #2 start_eval = 1'b0;
        repeat (2) @(posedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule